// File: doc/BRIEF.md
# Shift-and-Add Execution Unit with Result Forwarding

This block is a 64-bit integer execution unit. It computes `a + (b << s)` and can also act as a plain left barrel shifter. The left shift is built from six levels of 2:1 multiplexers, one level for each bit of the shift amount. Shifted-out bits are lost, and the sum wraps modulo 2^64.

The addend `a` comes through a forwarding multiplexer. It is either the register-file operand on the port or the unit's own most recently completed result. Dependent chains of additions can therefore issue every cycle without waiting for a write-back.

The latency depends on the shift amount. For amounts 0 through 4, only the three low shifter levels are non-trivial, so the adder takes their output directly and the result appears one cycle after acceptance. For amounts 5 through 63, the partially shifted operand is registered. The upper three levels and the adder then finish in a second cycle. During that second cycle the unit raises `busy` and refuses new operations.

Top module: `shadd_unit`

## Requirements
- R1: After reset, `res_valid` and `busy` are 0 and `res_data` is 0.
- R2: The result equals `A + (op_b << shamt)` modulo 2^64, with bits shifted past bit 63 discarded. `A` is the selected addend, and `shamt` is a 6-bit unsigned value.
- R3: An operation is accepted when `op_valid` is 1 and `busy` is 0 at a rising clock edge. An accepted operation with `shamt` of 0 to 4 sets `res_valid` at that edge, and `busy` stays 0.
- R4: An accepted operation with `shamt` of 5 to 63 sets `busy` (with `res_valid` 0) at that edge. At the next edge `res_valid` is 1 with the result and `busy` returns to 0.
- R5: `op_valid` is ignored while `busy` is 1. Such an operation produces no result and does not alter the pending result.
- R6: With `use_bypass` = 1, the addend is the last completed result instead of `op_a`. With `use_bypass` = 0, `op_a` is used.
- R7: Single-cycle operations that each forward the previous result issue on consecutive cycles, and each produces a correct result one cycle later.
- R8: With `shift_only` = 1, the addend is forced to zero and the result is `op_b << shamt`.
- R9: `res_valid` pulses exactly once per accepted operation and never otherwise.
- R10: `res_data` holds its value in every cycle in which `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_a | input | 64 | Register-file addend |
| op_b | input | 64 | Operand to be shifted |
| shamt | input | 6 | Left shift amount |
| use_bypass | input | 1 | 1 selects last result as addend |
| shift_only | input | 1 | 1 forces addend to zero |
| busy | output | 1 | Second cycle of a long-shift operation in progress |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 64 | Result, held between pulses |

## Verification
Directed cases place the shift amount at 0, 4, 5 and 63. These separate the single-cycle and two-cycle paths at their boundary and expose any lost or misplaced upper bits. Other directed cases cover chains of forwarded additions on consecutive cycles, an operation offered during `busy`, and shift-only operations. Together they distinguish the forwarding, ignoring and zero-addend behaviour from a plain register-operand add. A seeded random stream mixes all shift amounts, addend sources and modes with idle gaps, and each result is compared against a bench model of the sum and of the cycle it must appear in.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  localparam int DW = 64;
  localparam int SW = $clog2(DW);
  typedef logic [DW-1:0] word_t;

  // One barrel level: conditionally shift left by 2**lvl.
  function automatic word_t lvl_shift(word_t v, int lvl, logic en);
    return en ? (v << (1 << lvl)) : v;
  endfunction

  // Wrapping sum of addend and shifted operand.
  function automatic word_t wrap_add(word_t x, word_t y);
    return x + y;
  endfunction
endpackage

// File: rtl/shadd_shift_levels.sv
module shadd_shift_levels
  import shadd_pkg::*;
#(
  parameter int LO = 0,
  parameter int HI = 3
) (
  input  word_t             din,
  input  logic [HI-LO-1:0]  amt_bits,
  output word_t             dout
);
  localparam int NLV = HI - LO;
  word_t stg [NLV+1];

  assign stg[0] = din;
  for (genvar i = 0; i < NLV; i++) begin : g_lvl
    assign stg[i+1] = lvl_shift(stg[i], LO + i, amt_bits[i]);
  end
  assign dout = stg[NLV];
endmodule

// File: rtl/shadd_operand_sel.sv
module shadd_operand_sel
  import shadd_pkg::*;
(
  input  word_t reg_opnd,
  input  word_t fwd_opnd,
  input  logic  pick_fwd,
  input  logic  zero_it,
  output word_t addend
);
  always_comb begin
    if (zero_it)       addend = '0;
    else if (pick_fwd) addend = fwd_opnd;
    else               addend = reg_opnd;
  end
endmodule

// File: rtl/shadd_unit.sv
module shadd_unit
  import shadd_pkg::*;
#(
  parameter int FAST_MAX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [SW-1:0] shamt,
  input  logic          use_bypass,
  input  logic          shift_only,
  output logic          busy,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  localparam int EARLY_LVLS = $clog2(FAST_MAX + 1);
  localparam int LATE_LVLS  = SW - EARLY_LVLS;

  word_t res_q, addend, early_b, late_b, fast_sum, slow_sum;
  word_t pend_a, pend_b;
  logic [LATE_LVLS-1:0] pend_amt;
  logic busy_q, vld_q;

  // Named events for the checker.
  logic acc_fire, acc_fast;
  assign acc_fire = op_valid & ~busy_q;
  assign acc_fast = acc_fire & (shamt <= SW'(FAST_MAX));

  shadd_operand_sel u_sel (
    .reg_opnd (op_a),
    .fwd_opnd (res_q),
    .pick_fwd (use_bypass),
    .zero_it  (shift_only),
    .addend   (addend)
  );

  shadd_shift_levels #(.LO(0), .HI(EARLY_LVLS)) u_early (
    .din      (op_b),
    .amt_bits (shamt[EARLY_LVLS-1:0]),
    .dout     (early_b)
  );

  shadd_shift_levels #(.LO(EARLY_LVLS), .HI(SW)) u_late (
    .din      (pend_b),
    .amt_bits (pend_amt),
    .dout     (late_b)
  );

  assign fast_sum = wrap_add(addend, early_b);
  assign slow_sum = wrap_add(pend_a, late_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      vld_q    <= 1'b0;
      busy_q   <= 1'b0;
      pend_a   <= '0;
      pend_b   <= '0;
      pend_amt <= '0;
    end else if (busy_q) begin
      res_q  <= slow_sum;
      vld_q  <= 1'b1;
      busy_q <= 1'b0;
    end else if (acc_fast) begin
      res_q  <= fast_sum;
      vld_q  <= 1'b1;
    end else if (acc_fire) begin
      pend_a   <= addend;
      pend_b   <= early_b;
      pend_amt <= shamt[SW-1:EARLY_LVLS];
      busy_q   <= 1'b1;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign res_valid = vld_q;
  assign res_data  = res_q;
endmodule

// File: rtl/shadd_unit_chk.sv
module shadd_unit_chk
  import shadd_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [SW-1:0] shamt,
  input logic          use_bypass,
  input logic          shift_only,
  input logic          busy,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic          acc_fire,
  input logic          acc_fast
);
  assert_fast_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fast |=> (res_valid && !busy));

  assert_slow_goes_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !acc_fast) |=> (busy && !res_valid));

  assert_busy_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (res_valid && !busy));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_valid) |=> !res_valid);

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (res_valid || $stable(res_data)));

  assert_fast_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fast && !use_bypass && !shift_only) |=>
      (res_data == $past(op_a + (op_b << shamt))));

  assert_shift_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fast && shift_only) |=> (res_data == $past(op_b << shamt)));
endmodule

bind shadd_unit shadd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
  .shamt(shamt), .use_bypass(use_bypass), .shift_only(shift_only),
  .busy(busy), .res_valid(res_valid), .res_data(res_data),
  .acc_fire(acc_fire), .acc_fast(acc_fast)
);

// File: tb/tb_shadd_unit.sv
module tb_shadd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [5:0]  shamt = '0;
  logic        use_bypass = 1'b0, shift_only = 1'b0;
  logic        busy, res_valid;
  logic [63:0] res_data;

  int n_chk = 0, n_fail = 0;
  logic [63:0] last_res = '0;
  int unsigned seed = 32'h5eed_1234;

  always #4 clk = ~clk;

  shadd_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .shamt(shamt), .use_bypass(use_bypass), .shift_only(shift_only),
    .busy(busy), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        int s, logic byp, logic so,
                                        logic [63:0] prev);
    logic [63:0] add, sh;
    add = so ? 64'd0 : (byp ? prev : a);
    sh  = '0;
    for (int k = 0; k < 64; k++) if (k + s < 64) sh[k+s] = b[k];
    return add + sh;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input int s,
                       input logic byp, input logic so);
    op_valid = 1'b1; op_a = a; op_b = b; shamt = 6'(s);
    use_bypass = byp; shift_only = so;
  endtask

  task automatic idle();
    op_valid = 1'b0; op_a = '0; op_b = '0; shamt = '0;
    use_bypass = 1'b0; shift_only = 1'b0;
  endtask

  // Issue one op, check latency and value, leave inputs idle.
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input int s,
                        input logic byp, input logic so, input string tag);
    logic [63:0] exp;
    exp = model(a, b, s, byp, so, last_res);
    drive(a, b, s, byp, so);
    @(posedge clk); #1;
    idle();
    if (s <= 4) begin
      chk(res_valid && !busy, {tag, " R3 fast latency"}, {62'd0, busy, res_valid}, 64'd1);
    end else begin
      chk(busy && !res_valid, {tag, " R4 busy cycle"}, {62'd0, busy, res_valid}, 64'd2);
      @(posedge clk); #1;
      chk(res_valid && !busy, {tag, " R4 done"}, {62'd0, busy, res_valid}, 64'd1);
    end
    chk(res_data == exp, {tag, " R2 value"}, res_data, exp);
    last_res = exp;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!res_valid && !busy && res_data == 0, "R1 reset state", res_data, 64'd0);
    rst_n = 1'b1;

    // Boundary shift amounts
    run_op(64'd10, 64'h1, 0, 0, 0, "s0");
    run_op(64'd3, 64'hF000_0000_0000_0001, 4, 0, 0, "s4 discards R2");
    run_op(64'd3, 64'h8000_0000_0000_0003, 5, 0, 0, "s5");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 63, 0, 0, "s63 wrap");

    // R6 forwarding on both paths; R8 shift-only
    run_op(64'hDEAD, 64'h2, 1, 1, 0, "R6 fwd fast");
    run_op(64'hBEEF, 64'h7, 40, 1, 0, "R6 fwd slow");
    run_op(64'h1234, 64'h9, 3, 0, 1, "R8 shift-only fast");
    run_op(64'h1234, 64'h9, 17, 1, 1, "R8 shift-only slow");

    // R7 back-to-back dependent fast ops
    begin
      logic [63:0] e;
      for (int i = 0; i < 6; i++) begin
        e = model(64'h0, 64'(i + 1), i % 5, (i != 0), 0, last_res);
        drive(64'h0, 64'(i + 1), i % 5, (i != 0), 0);
        @(posedge clk); #1;
        chk(res_valid && res_data == e, "R7 back-to-back", res_data, e);
        last_res = e;
      end
      idle();
      @(posedge clk); #1;
      chk(!res_valid, "R9 no pulse when idle", {63'd0, res_valid}, 64'd0);
      chk(res_data == last_res, "R10 hold", res_data, last_res);
    end

    // R5: op offered during busy is ignored
    begin
      logic [63:0] e;
      e = model(64'h100, 64'h5, 8, 0, 0, last_res);
      drive(64'h100, 64'h5, 8, 0, 0);
      @(posedge clk); #1;
      drive(64'h7777, 64'h1, 0, 0, 0);
      @(posedge clk); #1;
      idle();
      chk(res_valid && res_data == e, "R5 pending result kept", res_data, e);
      last_res = e;
      @(posedge clk); #1;
      chk(!res_valid, "R5 ignored op no result R9", {63'd0, res_valid}, 64'd0);
      chk(res_data == e, "R5 R10 data unchanged", res_data, e);
    end

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      int s;
      logic byp, so;
      a = {$urandom(seed), $urandom(seed)};
      seed = seed + 1;
      b = {$urandom(), $urandom()};
      s = int'($urandom() % 64);
      if ($urandom() % 3 == 0) s = int'($urandom() % 5);
      byp = 1'($urandom());
      so = ($urandom() % 5 == 0);
      run_op(a, b, s, byp, so, "random");
      if ($urandom() % 4 == 0) begin
        @(posedge clk); #1;
        chk(!res_valid && res_data == last_res, "random gap R9 R10", res_data, last_res);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule